// File: doc/BRIEF.md
# Pipelined Burst SRAM Access Controller

This block is a synthesizable model of a synchronous, pipelined static RAM with burst capability. It holds the command decoder, a burst address generator, a byte-lane write datapath and a pipelined output stage. Every control, address and data input is sampled on the rising clock edge.

A burst can start from either of two strobes, and the two strobes follow different rules. A start from the processor strobe is always a read. It needs the primary chip enable and is ignored while that enable is inactive. A start from the controller strobe becomes a write when a write is requested, and a read otherwise. The controller strobe can also deselect the device. After a start, the burst-advance input either steps to the next address in the chosen burst order or holds the current address, which gives a wait state. The primary enable does not stop a burst that is already running.

Read data leaves through a registered output one clock after the address edge. When the device is deselected, the output driver stays on for one extra cycle so that the last pipelined read can still be taken. The data-input, data-output and drive-enable ports are separate. Each byte lane can carry an extra parity bit.

Top module: `pbsram_core`

## Requirements
- R1: On an edge where `strb_proc_n` is low, `sel_n` is low, `sel2` is high and `sel3_n` is low, a burst starts at `addr` as a read, and no lane is written at that edge whatever the write controls say.
- R2: While `sel_n` is high, `strb_proc_n` has no effect. An edge with `strb_ctrl_n` low while `sel_n` is high deselects the device.
- R3: `sel2` and `sel3_n` are looked at only on edges where a start strobe is low. A start with `sel2` low or `sel3_n` high deselects the device. Changing them during a running burst changes nothing.
- R4: An edge with `strb_ctrl_n` low (and `strb_proc_n` high or masked) and all chip enables active starts a burst at `addr`. It is a write when a write is requested and a read otherwise.
- R5: A write is requested when `wr_all_n` is low, or when `wr_lane_en_n` is low and at least one bit of `lane_wr_n` is low. A low `wr_all_n` writes every lane regardless of `lane_wr_n`.
- R6: Bit i of `lane_wr_n` controls lane i, which occupies bits [i*(LANE_W+1) +: LANE_W+1] of `din`/`dout`, with the parity bit as the top bit of the lane. Lanes that are not enabled keep their stored value.
- R7: On an edge with both start strobes high during an active burst, a low `step_n` moves to the next burst address and a high `step_n` stays at the current address. The read or write still takes place at the address chosen.
- R8: The low BURST_W address bits follow the start value plus the step count modulo 2^BURST_W when `seq_ilv` is 0, and the start value XOR the step count when `seq_ilv` is 1. The upper address bits stay fixed for the whole burst.
- R9: A running burst goes on while `sel_n` is high, as long as no start strobe is low.
- R10: Data read at edge N appears on `dout` after edge N+1, with `dout_oe` high. A write at edge N turns `dout_oe` low after edge N+1.
- R11: `dout_oe` is low whenever `out_en_n` is high, with no clock edge needed.
- R12: After a deselect at edge N, `dout_oe` stays high with the last read data until edge N+2 and is low after it.
- R13: After reset, `dout_oe` is low and no burst is active. Edges without a start strobe then write nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Word address used at a burst start |
| strb_proc_n | input | 1 | Processor start strobe, active low |
| strb_ctrl_n | input | 1 | Controller start strobe, active low |
| step_n | input | 1 | Burst advance, active low; high suspends |
| sel_n | input | 1 | Primary chip enable, active low |
| sel2 | input | 1 | Secondary chip enable, active high |
| sel3_n | input | 1 | Secondary chip enable, active low |
| wr_all_n | input | 1 | Write all lanes, active low |
| wr_lane_en_n | input | 1 | Enables the per-lane write bits, active low |
| lane_wr_n | input | LANES | Per-lane write enables, active low |
| seq_ilv | input | 1 | Burst order: 0 linear, 1 interleaved; keep static |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| din | input | LANES*(LANE_W+PARITY_EN) | Write data |
| dout | output | LANES*(LANE_W+PARITY_EN) | Registered read data |
| dout_oe | output | 1 | High when `dout` is to be driven |

## Verification
The bench goes after the cases where the two start strobes behave differently. A processor start with the write controls low must not store anything. A processor strobe while the primary enable is off must let a running burst carry on and write at the next address. A design that treats both strobes the same would corrupt memory in the first case and restart the burst in the second. Byte masks with and without the global override are read back lane by lane, parity bit included, so a wrong lane decode shows up as changed neighbour bytes. Burst walks in both orders from a non-zero start, with suspend cycles between steps, expose a wrong wrap or a suspend that still advances. Reads followed by deselects check that the driver stays on for exactly two edges: a single-cycle deselect, or one that never releases, fails there.

// File: rtl/pbs_pkg.sv
package pbs_pkg;

   // Operation carried out at one clock edge
   typedef enum logic [1:0] {
      OP_NONE  = 2'd0,
      OP_READ  = 2'd1,
      OP_WRITE = 2'd2
   } pbs_op_e;

endpackage

// File: rtl/pbs_cmd_dec.sv
module pbs_cmd_dec
   import pbs_pkg::*;
#(
   parameter int LANES = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             strb_proc_n,
   input  logic             strb_ctrl_n,
   input  logic             step_n,
   input  logic             sel_n,
   input  logic             sel2,
   input  logic             sel3_n,
   input  logic             wr_all_n,
   input  logic             wr_lane_en_n,
   input  logic [LANES-1:0] lane_wr_n,
   output logic             load,
   output logic             step,
   output pbs_op_e          op,
   output logic [LANES-1:0] we_mask
);

   logic             active_q;
   logic             active_nx;
   logic             proc_hit;
   logic             start;
   logic             chips_ok;
   logic             wr_req;
   logic [LANES-1:0] lane_sel;

   always_comb begin
      // processor strobe only counts while the primary enable is active
      proc_hit = !strb_proc_n && !sel_n;
      start    = proc_hit || !strb_ctrl_n;
      chips_ok = !sel_n && sel2 && !sel3_n;

      if (!wr_all_n)          lane_sel = '1;
      else if (!wr_lane_en_n) lane_sel = ~lane_wr_n;
      else                    lane_sel = '0;
      wr_req = |lane_sel;

      load      = 1'b0;
      step      = 1'b0;
      op        = OP_NONE;
      active_nx = active_q;

      if (start) begin
         if (chips_ok) begin
            load      = 1'b1;
            active_nx = 1'b1;
            op        = (!proc_hit && wr_req) ? OP_WRITE : OP_READ;
         end else begin
            active_nx = 1'b0;
         end
      end else if (active_q) begin
         step = !step_n;
         op   = wr_req ? OP_WRITE : OP_READ;
      end

      we_mask = (op == OP_WRITE) ? lane_sel : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) active_q <= 1'b0;
      else        active_q <= active_nx;
   end

   p_proc_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!strb_proc_n && !sel_n) |-> (we_mask == '0));

   p_desel_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_n && !strb_ctrl_n) |=> (load || op == OP_NONE));

   p_global_all_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_all_n && op == OP_WRITE) |-> (&we_mask));

   p_keep_burst_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && strb_proc_n && strb_ctrl_n) |-> (op != OP_NONE));

endmodule

// File: rtl/pbs_burst_gen.sv
module pbs_burst_gen #(
   parameter int ADDR_W  = 6,
   parameter int BURST_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              step,
   input  logic              seq_ilv,
   input  logic [ADDR_W-1:0] ext_addr,
   output logic [ADDR_W-1:0] acc_addr
);

   localparam int HI_W = ADDR_W - BURST_W;
   localparam logic [BURST_W-1:0] CNT_ONE = BURST_W'(1);

   generate
      if (BURST_W < 1 || HI_W < 1) begin : g_bad_width
         $error("pbs_burst_gen: BURST_W must be in 1..ADDR_W-1");
      end
   endgenerate

   logic [HI_W-1:0]    hi_q;
   logic [BURST_W-1:0] lo_q;
   logic [BURST_W-1:0] cnt_q;
   logic [BURST_W-1:0] cnt_sel;
   logic [BURST_W-1:0] lo_mix;

   always_comb begin
      cnt_sel  = step ? (cnt_q + CNT_ONE) : cnt_q;
      lo_mix   = seq_ilv ? (lo_q ^ cnt_sel) : (lo_q + cnt_sel);
      acc_addr = load ? ext_addr : {hi_q, lo_mix};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q  <= '0;
         lo_q  <= '0;
         cnt_q <= '0;
      end else if (load) begin
         hi_q  <= ext_addr[ADDR_W-1:BURST_W];
         lo_q  <= ext_addr[BURST_W-1:0];
         cnt_q <= '0;
      end else if (step) begin
         cnt_q <= cnt_q + CNT_ONE;
      end
   end

   p_upper_fixed_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !load |-> (acc_addr[ADDR_W-1:BURST_W] == hi_q));

endmodule

// File: rtl/pbs_lane_mem.sv
module pbs_lane_mem #(
   parameter int ADDR_W = 6,
   parameter int LANES  = 4,
   parameter int LW     = 9
) (
   input  logic                clk,
   input  logic [LANES-1:0]    we_mask,
   input  logic [ADDR_W-1:0]   wr_addr,
   input  logic [LANES*LW-1:0] wr_data,
   input  logic [ADDR_W-1:0]   rd_addr,
   output logic [LANES*LW-1:0] rd_data
);

   localparam int DEPTH = 1 << ADDR_W;

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         logic [LW-1:0] cells [DEPTH];

         always_ff @(posedge clk) begin
            if (we_mask[g]) cells[wr_addr] <= wr_data[g*LW +: LW];
         end

         assign rd_data[g*LW +: LW] = cells[rd_addr];
      end
   endgenerate

endmodule

// File: rtl/pbs_out_stage.sv
module pbs_out_stage #(
   parameter int DW = 36
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd_vld,
   input  logic          act,
   input  logic [DW-1:0] rd_data,
   output logic [DW-1:0] dout,
   output logic          drive
);

   logic [DW-1:0] dout_q;
   logic          drive_q;
   logic          pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout_q  <= '0;
         drive_q <= 1'b0;
         pend_q  <= 1'b1;
      end else begin
         pend_q <= !act;
         if (rd_vld) begin
            dout_q  <= rd_data;
            drive_q <= 1'b1;
         end else if (act) begin
            drive_q <= 1'b0;
         end else if (pend_q) begin
            drive_q <= 1'b0;
         end
      end
   end

   assign dout  = dout_q;
   assign drive = drive_q;

   p_read_drive_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rd_vld |=> drive);

   p_write_blank_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (act && !rd_vld) |=> !drive);

   p_two_cycle_off_r12: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(drive_q) && !$past(act)) |-> !$past(act, 2));

endmodule

// File: rtl/pbsram_core.sv
module pbsram_core
   import pbs_pkg::*;
#(
   parameter int ADDR_W    = 6,
   parameter int BURST_W   = 2,
   parameter int LANES     = 4,
   parameter int LANE_W    = 8,
   parameter int PARITY_EN = 1,
   localparam int LW       = LANE_W + PARITY_EN,
   localparam int DW       = LANES * LW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              strb_proc_n,
   input  logic              strb_ctrl_n,
   input  logic              step_n,
   input  logic              sel_n,
   input  logic              sel2,
   input  logic              sel3_n,
   input  logic              wr_all_n,
   input  logic              wr_lane_en_n,
   input  logic [LANES-1:0]  lane_wr_n,
   input  logic              seq_ilv,
   input  logic              out_en_n,
   input  logic [DW-1:0]     din,
   output logic [DW-1:0]     dout,
   output logic              dout_oe
);

   generate
      if (PARITY_EN != 0 && PARITY_EN != 1) begin : g_bad_parity
         $error("pbsram_core: PARITY_EN must be 0 or 1");
      end
      if (LANES < 1 || LANE_W < 1) begin : g_bad_lanes
         $error("pbsram_core: LANES and LANE_W must be positive");
      end
   endgenerate

   logic              dec_load;
   logic              dec_step;
   pbs_op_e           dec_op;
   logic [LANES-1:0]  dec_we;
   logic [ADDR_W-1:0] acc_addr;
   logic [DW-1:0]     rd_data;
   logic              drive;

   // first pipeline stage: the access chosen at this edge
   logic              rd_vld_q;
   logic              act_q;
   logic [ADDR_W-1:0] rd_addr_q;

   pbs_cmd_dec #(.LANES(LANES)) u_dec (
      .clk          (clk),
      .rst_n        (rst_n),
      .strb_proc_n  (strb_proc_n),
      .strb_ctrl_n  (strb_ctrl_n),
      .step_n       (step_n),
      .sel_n        (sel_n),
      .sel2         (sel2),
      .sel3_n       (sel3_n),
      .wr_all_n     (wr_all_n),
      .wr_lane_en_n (wr_lane_en_n),
      .lane_wr_n    (lane_wr_n),
      .load         (dec_load),
      .step         (dec_step),
      .op           (dec_op),
      .we_mask      (dec_we)
   );

   pbs_burst_gen #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_burst (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (dec_load),
      .step     (dec_step),
      .seq_ilv  (seq_ilv),
      .ext_addr (addr),
      .acc_addr (acc_addr)
   );

   pbs_lane_mem #(.ADDR_W(ADDR_W), .LANES(LANES), .LW(LW)) u_mem (
      .clk     (clk),
      .we_mask (dec_we),
      .wr_addr (acc_addr),
      .wr_data (din),
      .rd_addr (rd_addr_q),
      .rd_data (rd_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_vld_q  <= 1'b0;
         act_q     <= 1'b0;
         rd_addr_q <= '0;
      end else begin
         rd_vld_q  <= (dec_op == OP_READ);
         act_q     <= (dec_op != OP_NONE);
         rd_addr_q <= acc_addr;
      end
   end

   pbs_out_stage #(.DW(DW)) u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_vld  (rd_vld_q),
      .act     (act_q),
      .rd_data (rd_data),
      .dout    (dout),
      .drive   (drive)
   );

   assign dout_oe = drive && !out_en_n;

   p_start_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      dec_load |-> (acc_addr == addr));

endmodule

// File: tb/sim_pbsram_core.sv
module sim_pbsram_core;

   localparam int AW    = 6;
   localparam int LN    = 4;
   localparam int LW    = 9;
   localparam int DW    = LN * LW;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic          strb_proc_n = 1'b1, strb_ctrl_n = 1'b1, step_n = 1'b1;
   logic          sel_n = 1'b0, sel2 = 1'b1, sel3_n = 1'b0;
   logic          wr_all_n = 1'b1, wr_lane_en_n = 1'b1;
   logic [LN-1:0] lane_wr_n = '1;
   logic          seq_ilv = 1'b0, out_en_n = 1'b0;
   logic [DW-1:0] din = '0;
   logic [DW-1:0] dout;
   logic          dout_oe;

   int checks = 0;
   int fails  = 0;

   // reference state
   logic [DW-1:0] m_mem [DEPTH];
   logic          m_sel, m_rdv, m_act, m_drv, m_pend;
   logic [AW-1:0] m_base, m_rda;
   logic [1:0]    m_cnt;
   logic [DW-1:0] m_dq;

   always #5 clk = ~clk;

   pbsram_core u0 (
      .clk(clk), .rst_n(rst_n), .addr(addr), .strb_proc_n(strb_proc_n),
      .strb_ctrl_n(strb_ctrl_n), .step_n(step_n), .sel_n(sel_n), .sel2(sel2),
      .sel3_n(sel3_n), .wr_all_n(wr_all_n), .wr_lane_en_n(wr_lane_en_n),
      .lane_wr_n(lane_wr_n), .seq_ilv(seq_ilv), .out_en_n(out_en_n),
      .din(din), .dout(dout), .dout_oe(dout_oe)
   );

   function automatic logic [1:0] order(input logic [1:0] lo, input logic [1:0] c, input logic ilv);
      return ilv ? (lo ^ c) : (lo + c);
   endfunction

   task automatic model_reset();
      m_sel = 0; m_rdv = 0; m_act = 0; m_drv = 0; m_pend = 1;
      m_base = '0; m_rda = '0; m_cnt = '0; m_dq = '0;
   endtask

   // expected effect of one rising edge, from R1..R13
   task automatic model_edge();
      logic          p_hit, start, ok, wr;
      logic [LN-1:0] mask;
      logic [AW-1:0] a;
      int            op;   // 0 none, 1 read, 2 write
      if (m_rdv) begin
         m_dq = m_mem[m_rda]; m_drv = 1;
      end else if (m_act) begin
         m_drv = 0;
      end else if (m_pend) begin
         m_drv = 0;
      end
      m_pend = !m_act;
      p_hit = !strb_proc_n && !sel_n;
      start = p_hit || !strb_ctrl_n;
      ok    = !sel_n && sel2 && !sel3_n;
      mask  = !wr_all_n ? '1 : (!wr_lane_en_n ? ~lane_wr_n : '0);
      wr    = |mask;
      op = 0; a = '0;
      if (start) begin
         if (ok) begin
            a = addr; m_base = addr; m_cnt = 0; m_sel = 1;
            op = (!p_hit && wr) ? 2 : 1;
         end else m_sel = 0;
      end else if (m_sel) begin
         if (!step_n) m_cnt = m_cnt + 1;
         a  = {m_base[AW-1:2], order(m_base[1:0], m_cnt, seq_ilv)};
         op = wr ? 2 : 1;
      end
      if (op == 2)
         for (int l = 0; l < LN; l++)
            if (mask[l]) m_mem[a][l*LW +: LW] = din[l*LW +: LW];
      m_rdv = (op == 1); m_act = (op != 0); m_rda = a;
   endtask

   task automatic compare(input string tag);
      logic e_oe;
      e_oe = m_drv && !out_en_n;
      checks++;
      if (dout_oe !== e_oe || (e_oe && dout !== m_dq)) begin
         fails++;
         $display("FAIL %s: actual dout_oe=%b dout=%h expected dout_oe=%b dout=%h",
                  tag, dout_oe, dout, e_oe, m_dq);
      end
   endtask

   task automatic run(input string tag, input int n);
      repeat (n) begin
         model_edge();
         @(posedge clk);
         #1;
         compare(tag);
      end
   endtask

   task automatic idle();
      strb_proc_n = 1; strb_ctrl_n = 1; step_n = 1;
      sel_n = 0; sel2 = 1; sel3_n = 0;
      wr_all_n = 1; wr_lane_en_n = 1; lane_wr_n = '1; out_en_n = 0;
   endtask

   task automatic rnd_din();
      logic [63:0] r;
      r = {$urandom(), $urandom()};
      din = r[DW-1:0];
   endtask

   task automatic do_reset();
      idle();
      rst_n = 0;
      repeat (3) @(posedge clk);
      model_reset();
      @(negedge clk);
      rst_n = 1;
      #1;
      compare("R13 reset");
   endtask

   // ctrl-strobe read start at a, then n suspended cycles
   task automatic read_at(input string tag, input logic [AW-1:0] a);
      idle(); addr = a; strb_ctrl_n = 0;
      run(tag, 1);
      idle();
      run(tag, 2);
   endtask

   task automatic deselect(input string tag);
      idle(); sel_n = 1; strb_ctrl_n = 0;
      run(tag, 1);
      idle();
      run(tag, 2);
   endtask

   initial begin
      #2_000_000;
      fails++;
      $display("FAIL R13 watchdog: actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'h1F2E3D4C));
      do_reset();

      // fill every word with four-beat linear write bursts
      for (int b = 0; b < DEPTH / 4; b++) begin
         idle(); addr = AW'(b * 4); strb_ctrl_n = 0; wr_all_n = 0; rnd_din();
         run("R5 fill", 1);
         strb_ctrl_n = 1; step_n = 0;
         for (int k = 0; k < 3; k++) begin rnd_din(); run("R7 fill", 1); end
      end
      deselect("R12 fill");

      // R13: after reset, write controls without a start store nothing
      do_reset();
      idle(); wr_all_n = 0; step_n = 0; rnd_din();
      run("R13", 3);
      read_at("R13", 6'd0);
      read_at("R13", 6'd1);
      deselect("R13");

      // R1: processor start with write controls low is a read
      idle(); addr = 6'd5; strb_proc_n = 0; wr_all_n = 0; rnd_din();
      run("R1", 1);
      idle();
      run("R1", 2);
      // a later edge of the same burst may write
      wr_all_n = 0; rnd_din();
      run("R1", 1);
      idle();
      run("R1", 3);
      deselect("R1");

      // R2: processor strobe masked while primary enable is off
      read_at("R2", 6'd9);
      idle(); sel_n = 1; strb_proc_n = 0; step_n = 0; wr_all_n = 0; rnd_din();
      run("R2", 1);
      idle();
      run("R2", 2);
      deselect("R2");
      idle(); sel_n = 1; strb_proc_n = 0; wr_all_n = 0; rnd_din();
      run("R2", 3);
      read_at("R2", 6'd10);
      read_at("R2", 6'd8);
      deselect("R2");

      // R3: secondary enables only matter at starts
      idle(); addr = 6'd14; strb_ctrl_n = 0; sel2 = 0; wr_all_n = 0; rnd_din();
      run("R3", 2);
      idle(); addr = 6'd14; strb_proc_n = 0; sel3_n = 1;
      run("R3", 2);
      read_at("R3", 6'd14);
      idle(); sel2 = 0; sel3_n = 1; step_n = 0;
      run("R3", 3);
      deselect("R3");

      // R4: controller start writes when asked, reads otherwise
      idle(); addr = 6'd12; strb_ctrl_n = 0; wr_all_n = 0; rnd_din();
      run("R4", 1);
      idle(); addr = 6'd12; strb_ctrl_n = 0;
      run("R4", 1);
      idle();
      run("R4", 2);
      deselect("R4");

      // R5 / R6: lane masks, parity bits, global override
      idle(); addr = 6'd20; strb_ctrl_n = 0; wr_lane_en_n = 0; lane_wr_n = 4'b1010; rnd_din();
      run("R6", 1);
      idle(); wr_lane_en_n = 1; lane_wr_n = 4'b0000; rnd_din();
      run("R5", 1);
      idle(); wr_lane_en_n = 0; lane_wr_n = 4'b0111; din = {DW{1'b1}};
      run("R6", 1);
      idle(); wr_all_n = 0; wr_lane_en_n = 1; lane_wr_n = 4'b1111; rnd_din();
      run("R5", 1);
      idle(); wr_all_n = 0; wr_lane_en_n = 0; lane_wr_n = 4'b1110; rnd_din();
      run("R5", 1);
      idle();
      run("R6", 3);
      read_at("R6", 6'd20);
      deselect("R6");

      // R7 / R8: burst walks in both orders with suspends
      seq_ilv = 0;
      read_at("R8", 6'h1E);
      for (int k = 0; k < 5; k++) begin
         idle(); step_n = 0; run("R8", 1);
         idle(); run("R7", 1);
      end
      deselect("R8");
      seq_ilv = 1;
      read_at("R8", 6'h21);
      for (int k = 0; k < 5; k++) begin
         idle(); step_n = 0; run("R8", 1);
         idle(); run("R7", 1);
      end
      deselect("R8");
      seq_ilv = 0;

      // R9: burst continues with primary enable off
      read_at("R9", 6'd33);
      idle(); sel_n = 1; step_n = 0;
      run("R9", 3);
      idle(); sel_n = 1; step_n = 0; wr_all_n = 0; rnd_din();
      run("R9", 1);
      idle(); sel_n = 1; step_n = 0;
      run("R9", 4);
      deselect("R9");

      // R11: output enable acts without a clock
      read_at("R11", 6'd40);
      out_en_n = 1; #1; compare("R11");
      out_en_n = 0; #1; compare("R11");
      deselect("R11");

      // R12: deselect keeps driving one extra cycle, then releases
      read_at("R12", 6'd44);
      idle(); step_n = 0;
      run("R12", 1);
      idle(); sel_n = 1; strb_ctrl_n = 0;
      run("R12", 1);
      idle(); sel_n = 1;
      run("R12", 3);
      // write then deselect: output already blank
      read_at("R12", 6'd45);
      idle(); wr_all_n = 0; rnd_din(); run("R10", 1);
      idle(); sel_n = 1; strb_ctrl_n = 0; run("R12", 1);
      idle(); run("R12", 2);

      // R10: constrained random traffic, linear then interleaved
      for (int ph = 0; ph < 2; ph++) begin
         seq_ilv = ph[0];
         for (int i = 0; i < 2500; i++) begin
            int r;
            r = int'($urandom_range(0, 15));
            strb_proc_n  = (r != 0);
            strb_ctrl_n  = !(r == 1 || r == 2);
            step_n       = $urandom_range(0, 1) != 0;
            sel_n        = $urandom_range(0, 7) == 0;
            sel2         = $urandom_range(0, 7) != 0;
            sel3_n       = $urandom_range(0, 7) == 0;
            wr_all_n     = $urandom_range(0, 3) != 0;
            wr_lane_en_n = $urandom_range(0, 1) != 0;
            lane_wr_n    = LN'($urandom());
            out_en_n     = $urandom_range(0, 7) == 0;
            addr         = AW'($urandom());
            rnd_din();
            run("R10", 1);
         end
         deselect("R10");
      end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

endmodule